// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block decides when an I2C slave holds the SCL line low so that software has time to refill its transmit buffer or empty its receive buffer. It keeps a single clock-release flag. When the flag is 0 the slave wants SCL held low, and when it is 1 the line is free. The bit engine drives the flag to 0 through two events. One is the falling edge of the acknowledge (ninth) clock during a slave transmit with an empty transmit buffer. The other is the end of a received byte during a slave receive while the stretch enable is set. Software drives the flag through a write strobe with a data bit. A stop condition and reset both force the flag back to 1.

The physical pull-down is gated by a synchronised copy of SCL. The slave only starts pulling once the master has already driven the line low, so a high phase that the master is producing is never cut short. Releasing the flag frees the line on the same clock edge. Every pin is a plain control or status level or a single-cycle pulse. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_sclhold_ctrl`

## Requirements
- R1: After reset, `rel_bit` is 1 and `scl_pull_low` is 0.
- R2: When `slave_tx`=1 and `ack_fall` pulses with `txbuf_full`=0, `rel_bit` becomes 0 on the next clock edge, whatever the value of `stretch_en`. With `txbuf_full`=1 the pulse leaves `rel_bit` unchanged.
- R3: When `slave_tx`=0 and `byte_done` pulses, `rel_bit` becomes 0 on the next edge only if `stretch_en`=1. A `byte_done` pulse in transmit direction and an `ack_fall` pulse in receive direction have no effect.
- R4: A strobe on `rel_wr` with `rel_wdata`=1 sets `rel_bit` to 1 on the next edge, for either value of `stretch_en`.
- R5: A strobe on `rel_wr` with `rel_wdata`=0 clears `rel_bit` when `stretch_en`=1. When `stretch_en`=0 the write is ignored and `rel_bit` keeps its value.
- R6: While SCL is low, `scl_pull_low` equals the inverse of `rel_bit`. When `rel_bit` rises, `scl_pull_low` falls on the same edge.
- R7: `scl_pull_low` never rises unless the synchronised SCL was low at that edge. A pending hold with SCL high begins pulling within `SYNC_STAGES`+1 cycles after SCL goes low.
- R8: `stop_seen` forces `rel_bit` to 1 and `scl_pull_low` to 0 on the next edge. It overrides every other input.
- R9: When a hardware stretch start and a software write happen in the same cycle, the hardware stretch wins and `rel_bit` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_tx | input | 1 | Transfer direction: 1 = slave transmits, 0 = slave receives |
| byte_done | input | 1 | Pulse at the end of a received byte |
| ack_fall | input | 1 | Pulse at the falling edge of the ninth clock |
| txbuf_full | input | 1 | Transmit buffer holds unsent data |
| stretch_en | input | 1 | Enables receive stretching and software clearing of the release flag |
| rel_wr | input | 1 | Software write strobe for the release flag |
| rel_wdata | input | 1 | Value written with `rel_wr` |
| stop_seen | input | 1 | Pulse on a stop condition |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_pull_low | output | 1 | Drive SCL low (open-drain enable) |
| rel_bit | output | 1 | Current clock-release flag |

## Verification
The hardest situation to reach is a hold that becomes pending while the master is still driving SCL high. The release flag drops at once, but the pull must wait until the synchronised line is seen low. The stimulus raises `scl_in`, fires a transmit stretch event, and checks that no pull appears while the line stays high. It then lowers the line and checks that the pull is still absent one cycle later and present once the synchroniser has settled. Same-cycle collisions are also hard to reach. The bench drives a stretch event together with a software set, and a stop together with a stretch event, in a single cycle to exercise the priority order.

// File: rtl/i2c_sclhold_pkg.sv
package i2c_sclhold_pkg;

  // Hardware stretch start sources decoded from bit-engine events.
  typedef struct packed {
    logic tx_start;   // transmit-side stretch: ninth clock, buffer empty
    logic rx_start;   // receive-side stretch: byte end, stretching enabled
  } stretch_evt_t;

  // Operation applied to the release flag in one cycle.
  typedef enum logic [1:0] {
    REL_KEEP = 2'd0,
    REL_SET  = 2'd1,
    REL_CLR  = 2'd2
  } rel_op_t;

endpackage

// File: rtl/i2c_sclhold_trigger.sv
module i2c_sclhold_trigger
  import i2c_sclhold_pkg::*;
(
  input  logic         slave_tx,
  input  logic         byte_done,
  input  logic         ack_fall,
  input  logic         txbuf_full,
  input  logic         stretch_en,
  output stretch_evt_t evt,
  output logic         hw_start
);

  always_comb begin
    // Transmit stretching ignores stretch_en entirely.
    evt.tx_start = slave_tx & ack_fall & ~txbuf_full;
    // Receive stretching is optional.
    evt.rx_start = ~slave_tx & byte_done & stretch_en;
    hw_start     = evt.tx_start | evt.rx_start;
  end

endmodule

// File: rtl/i2c_sclhold_relbit.sv
module i2c_sclhold_relbit
  import i2c_sclhold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_seen,
  input  logic hw_start,
  input  logic rel_wr,
  input  logic rel_wdata,
  input  logic stretch_en,
  output logic rel_q,
  output logic rel_next
);

  rel_op_t op;

  // Priority: stop, then hardware stretch start, then software write.
  always_comb begin
    op = REL_KEEP;
    if (stop_seen) begin
      op = REL_SET;
    end else if (hw_start) begin
      op = REL_CLR;
    end else if (rel_wr) begin
      if (rel_wdata) begin
        op = REL_SET;
      end else if (stretch_en) begin
        op = REL_CLR;
      end
    end
  end

  always_comb begin
    unique case (op)
      REL_SET: rel_next = 1'b1;
      REL_CLR: rel_next = 1'b0;
      default: rel_next = rel_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b1;
    end else begin
      rel_q <= rel_next;
    end
  end

endmodule

// File: rtl/i2c_sclhold_gate.sv
module i2c_sclhold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic rel_next,
  output logic scl_sync,
  output logic pull_q
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;

  // Synchroniser for the sensed line; idles high (bus released).
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= scl_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign scl_sync = chain[LAST];

  // Start pulling only once the line is seen low; keep pulling
  // while the hold is pending; drop with the release edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
    end else begin
      pull_q <= ~rel_next & (pull_q | ~scl_sync);
    end
  end

endmodule

// File: rtl/i2c_sclhold_ctrl.sv
module i2c_sclhold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_tx,
  input  logic byte_done,
  input  logic ack_fall,
  input  logic txbuf_full,
  input  logic stretch_en,
  input  logic rel_wr,
  input  logic rel_wdata,
  input  logic stop_seen,
  input  logic scl_in,
  output logic scl_pull_low,
  output logic rel_bit
);

  import i2c_sclhold_pkg::*;

  stretch_evt_t evt;
  logic         hw_start;
  logic         rel_q;
  logic         rel_next;
  logic         scl_sync;
  logic         pull_q;

  i2c_sclhold_trigger u_trig (
    .slave_tx   (slave_tx),
    .byte_done  (byte_done),
    .ack_fall   (ack_fall),
    .txbuf_full (txbuf_full),
    .stretch_en (stretch_en),
    .evt        (evt),
    .hw_start   (hw_start)
  );

  i2c_sclhold_relbit u_rel (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_seen  (stop_seen),
    .hw_start   (hw_start),
    .rel_wr     (rel_wr),
    .rel_wdata  (rel_wdata),
    .stretch_en (stretch_en),
    .rel_q      (rel_q),
    .rel_next   (rel_next)
  );

  i2c_sclhold_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .rel_next (rel_next),
    .scl_sync (scl_sync),
    .pull_q   (pull_q)
  );

  assign rel_bit      = rel_q;
  assign scl_pull_low = pull_q;

  logic unused_evt;
  assign unused_evt = ^evt;

endmodule

// File: rtl/i2c_sclhold_ctrl_chk.sv
module i2c_sclhold_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_tx,
  input logic byte_done,
  input logic ack_fall,
  input logic txbuf_full,
  input logic stretch_en,
  input logic rel_wr,
  input logic rel_wdata,
  input logic stop_seen,
  input logic scl_sync,
  input logic scl_pull_low,
  input logic rel_bit
);

  // R2: transmit stretch start clears the flag
  a_r2_tx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_tx && ack_fall && !txbuf_full && !stop_seen) |=> !rel_bit);

  // R3: receive stretch start clears the flag when enabled
  a_r3_rx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_tx && byte_done && stretch_en && !stop_seen) |=> !rel_bit);

  // R4: software set is always honoured
  a_r4_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_wr && rel_wdata && !stop_seen &&
     !(slave_tx && ack_fall && !txbuf_full) &&
     !(!slave_tx && byte_done && stretch_en)) |=> rel_bit);

  // R5: clearing write ignored when stretching disabled
  a_r5_sw_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_wr && !rel_wdata && !stretch_en && !stop_seen &&
     !(slave_tx && ack_fall && !txbuf_full)) |=> $stable(rel_bit));

  // R6: pull implies a pending hold
  a_r6_pull_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> !rel_bit);

  // R7: pull starts only after the line was seen low
  a_r7_pull_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> !$past(scl_sync));

  // R8: stop frees the line
  a_r8_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (rel_bit && !scl_pull_low));

endmodule

bind i2c_sclhold_ctrl i2c_sclhold_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_tx     (slave_tx),
  .byte_done    (byte_done),
  .ack_fall     (ack_fall),
  .txbuf_full   (txbuf_full),
  .stretch_en   (stretch_en),
  .rel_wr       (rel_wr),
  .rel_wdata    (rel_wdata),
  .stop_seen    (stop_seen),
  .scl_sync     (scl_sync),
  .scl_pull_low (scl_pull_low),
  .rel_bit      (rel_bit)
);

// File: tb/test_i2c_sclhold_ctrl.sv
`timescale 1ns/1ps
module test_i2c_sclhold_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_tx = 0, byte_done = 0, ack_fall = 0, txbuf_full = 0;
  logic stretch_en = 0, rel_wr = 0, rel_wdata = 0, stop_seen = 0;
  logic scl_in = 0;
  logic scl_pull_low, rel_bit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_sclhold_ctrl i_i2c_sclhold_ctrl (
    .clk(clk), .rst_n(rst_n), .slave_tx(slave_tx), .byte_done(byte_done),
    .ack_fall(ack_fall), .txbuf_full(txbuf_full), .stretch_en(stretch_en),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata), .stop_seen(stop_seen),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .rel_bit(rel_bit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle of pulses at a negedge, clear them at the next negedge.
  task automatic pulse(input logic bd, input logic af, input logic wr,
                       input logic wd, input logic st);
    byte_done = bd; ack_fall = af; rel_wr = wr; rel_wdata = wd; stop_seen = st;
    @(negedge clk);
    byte_done = 0; ack_fall = 0; rel_wr = 0; rel_wdata = 0; stop_seen = 0;
  endtask

  task automatic free_line();
    pulse(0, 0, 0, 0, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rel_bit, 1'b1);
    check("R1", scl_pull_low, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);  // scl_in low has reached the synchroniser

    // R2/R3 sweep: all event, direction, buffer and enable combinations.
    for (int i = 0; i < 32; i++) begin
      logic bd, af, dir, full, sen, exp_rel;
      {bd, af, dir, full, sen} = 5'(i);
      free_line();
      slave_tx = dir; txbuf_full = full; stretch_en = sen;
      pulse(bd, af, 0, 0, 0);
      exp_rel = !((dir & af & !full) | (!dir & bd & sen));
      check(dir ? "R2" : "R3", rel_bit, exp_rel);
      check("R6", scl_pull_low, !exp_rel);
    end

    // R4/R5 sweep: starting flag, enable and written value.
    slave_tx = 0; txbuf_full = 1;
    for (int i = 0; i < 8; i++) begin
      logic init, sen, wd, exp_rel;
      {init, sen, wd} = 3'(i);
      free_line();
      if (!init) begin
        stretch_en = 1;
        pulse(0, 0, 1, 0, 0);
      end
      stretch_en = sen;
      pulse(0, 0, 1, wd, 0);
      exp_rel = wd ? 1'b1 : (sen ? 1'b0 : init);
      check(wd ? "R4" : "R5", rel_bit, exp_rel);
      check("R6", scl_pull_low, !exp_rel);
    end

    // R6: release drops the pull on the same edge.
    stretch_en = 1; slave_tx = 1; txbuf_full = 0;
    pulse(0, 1, 0, 0, 0);
    check("R6", scl_pull_low, 1'b1);
    pulse(0, 0, 1, 1, 0);
    check("R6", rel_bit, 1'b1);
    check("R6", scl_pull_low, 1'b0);

    // R9: stretch start beats same-cycle software set.
    pulse(0, 1, 1, 1, 0);
    check("R9", rel_bit, 1'b0);

    // R8: stop overrides a same-cycle stretch start.
    pulse(0, 1, 0, 0, 1);
    check("R8", rel_bit, 1'b1);
    check("R8", scl_pull_low, 1'b0);

    // R7: hold pending while SCL is high.
    scl_in = 1;
    repeat (4) @(negedge clk);
    pulse(0, 1, 0, 0, 0);
    check("R7", rel_bit, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", scl_pull_low, 1'b0);
    scl_in = 0;
    @(negedge clk);
    check("R7", scl_pull_low, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", scl_pull_low, 1'b1);

    // R5: with stretching disabled a clearing write leaves a released flag.
    free_line();
    stretch_en = 0;
    pulse(0, 0, 1, 0, 0);
    check("R5", rel_bit, 1'b1);
    check("R5", scl_pull_low, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule